// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects a group of interrupt request lines, gives each a priority level that software can change at any moment, and decides when one of them may interrupt the code that is running now. It picks the best pending, enabled, not-yet-active request. It offers that request to the core only if its priority beats the current running priority and no mask blocks it. When the core accepts the offer, the block marks the interrupt active and records it on a nesting stack. It also produces the exception number and the address of the table word that holds the handler's start address.

The running priority is derived from the set of active interrupts. A return handshake retires the interrupt taken most recently, so the priority that applied before it came back into force. Three mask registers gate acceptance: two block every request, and one blocks only requests at or below a programmable level. A relocatable table base sets where the handler address words live. Saving registers to the stack and reading the table word are left to the core.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the block offers no request, the running priority is the idle value 2**PRIO_W (8 by default), every line is disabled, all masks are clear and the table base is 0.
- R2: A line becomes pending on a low-to-high transition. A line held high produces no further pending event. A pending line stays pending while it is disabled or masked, and it is offered once it is enabled.
- R3: Among the eligible lines, the lowest numeric priority wins. On equal priority, the lower line index wins.
- R4: A request is offered only when its priority value is strictly lower than the running priority. An equal value does not preempt.
- R5: The exception number is line index + 16. The vector address is the table base + 4 × exception number.
- R6: When takeAck is high while intReq is high, the offered line leaves the pending state and becomes active at that clock edge. From the next cycle the running priority equals its priority.
- R7: A return retires the interrupt taken most recently, and the running priority becomes the minimum over the interrupts still active, or idle when none remain. A return while nothing is active is ignored.
- R8: An active line is never offered again until it is retired, even if its priority is raised or it gets a new edge meanwhile. A new edge keeps it pending, and it is offered after the return.
- R9: A priority write takes effect on arbitration in the cycle after the write.
- R10: With the all-block mask set, no request is offered. Clearing it brings back the pending request.
- R11: With the fault-level mask set, no request is offered. Clearing it brings back the pending request.
- R12: A nonzero threshold blocks every request whose priority value is greater than or equal to the threshold. A threshold of 0 blocks nothing.
- R13: Register write selectors: 0 = priority of line regIdx from regData[PRIO_W-1:0]; 1 = enable bits from regData[NUM_IRQ-1:0]; 2 = all-block mask from regData[0]; 3 = threshold from regData[PRIO_W-1:0]; 4 = fault-level mask from regData[0]; 5 = table base from regData with bits [1:0] forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | NUM_IRQ | Interrupt request lines |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register selector (see R13) |
| regIdx | input | $clog2(NUM_IRQ) | Line index for priority writes |
| regData | input | ADDR_W | Write data |
| takeAck | input | 1 | Core accepts the offered interrupt |
| retStrobe | input | 1 | Core returns from the current handler |
| intReq | output | 1 | An interrupt is offered for preemption |
| excNum | output | 8 | Exception number of the offered line |
| vecAddr | output | ADDR_W | Address of the table word for the offered line |
| runPrio | output | PRIO_W+1 | Current running priority (2**PRIO_W when idle) |

## Verification
Arbitration is tried with simultaneous requests of mixed priority, then with equal priorities, and again after a priority rewrite. These patterns separate a value-first choice from an index-first choice and show that rewrites act at once. Nesting is tried with a strictly better request, an equal one and a worse one while a handler runs. This separates strict from non-strict preemption and shows that the earlier running priority comes back in the right order on return. Masks, the threshold, the enable bits, held lines and rewrites of an active line's priority are each applied to an already-pending request. These tests show that each one holds the request back without losing it.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  typedef enum logic [2:0] {
    SEL_PRIO      = 3'd0,
    SEL_ENABLE    = 3'd1,
    SEL_ALLMASK   = 3'd2,
    SEL_THRESH    = 3'd3,
    SEL_FAULTMASK = 3'd4,
    SEL_BASE      = 3'd5
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;
    logic pop;
  } ctlStrobe_t;
endpackage

// File: rtl/irqn_arb.sv
module irqn_arb #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]             elig,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prioIn,
  output logic                           bestValid,
  output logic [IDX_W-1:0]               bestIdx,
  output logic [PRIO_W-1:0]              bestPrio
);
  // strict compare keeps the lower index on ties
  always_comb begin
    bestValid = 1'b0;
    bestIdx   = '0;
    bestPrio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!bestValid || prioIn[i] < bestPrio)) begin
        bestValid = 1'b1;
        bestIdx   = IDX_W'(i);
        bestPrio  = prioIn[i];
      end
    end
  end
endmodule

// File: rtl/irqn_dp.sv
module irqn_dp
  import irqn_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 32,
  parameter int EXC_OFS = 16,
  parameter int EXC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int DEP_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqLine,
  input  logic               regWrEn,
  input  logic [2:0]         regSel,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [ADDR_W-1:0]  regData,
  input  ctlStrobe_t         strobe,
  output logic               bestValid,
  output logic [PRIO_W-1:0]  bestPrio,
  output logic [PRIO_W:0]    runPrio,
  output logic               allMask,
  output logic               faultMask,
  output logic [PRIO_W-1:0]  thresh,
  output logic [DEP_W-1:0]   depth,
  output logic [EXC_W-1:0]   excNum,
  output logic [ADDR_W-1:0]  vecAddr
);
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

  logic [NUM_IRQ-1:0][PRIO_W-1:0] prioReg;
  logic [NUM_IRQ-1:0]             enReg, pendReg, actReg, irqPrev;
  logic [NUM_IRQ-1:0][IDX_W-1:0]  nestStack;
  logic [ADDR_W-1:0]              tableBase;
  logic [IDX_W-1:0]               bestIdx;
  logic [NUM_IRQ-1:0]             takeMask, popMask, elig;
  logic [IDX_W-1:0]               topIdx;

  assign elig = pendReg & enReg & ~actReg;

  irqn_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uArb (
    .elig(elig), .prioIn(prioReg),
    .bestValid(bestValid), .bestIdx(bestIdx), .bestPrio(bestPrio)
  );

  // running priority follows the live priority of active lines
  always_comb begin
    runPrio = IDLE;
    for (int i = 0; i < NUM_IRQ; i++)
      if (actReg[i] && {1'b0, prioReg[i]} < runPrio) runPrio = {1'b0, prioReg[i]};
  end

  assign topIdx   = nestStack[IDX_W'(depth - DEP_W'(1))];
  assign takeMask = strobe.take ? (NUM_IRQ'(1) << bestIdx) : '0;
  assign popMask  = strobe.pop  ? (NUM_IRQ'(1) << topIdx)  : '0;
  assign excNum   = EXC_W'(bestIdx) + EXC_W'(EXC_OFS);
  assign vecAddr  = tableBase + (ADDR_W'(excNum) << 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioReg   <= '0;
      enReg     <= '0;
      pendReg   <= '0;
      actReg    <= '0;
      irqPrev   <= '0;
      nestStack <= '0;
      depth     <= '0;
      tableBase <= '0;
      allMask   <= 1'b0;
      faultMask <= 1'b0;
      thresh    <= '0;
    end else begin
      irqPrev <= irqLine;
      pendReg <= (pendReg & ~takeMask) | (irqLine & ~irqPrev);
      actReg  <= (actReg & ~popMask) | takeMask;
      if (strobe.take && strobe.pop) begin
        nestStack[IDX_W'(depth - DEP_W'(1))] <= bestIdx;
      end else if (strobe.take) begin
        nestStack[IDX_W'(depth)] <= bestIdx;
        depth <= depth + DEP_W'(1);
      end else if (strobe.pop) begin
        depth <= depth - DEP_W'(1);
      end
      if (regWrEn) begin
        case (regSel_e'(regSel))
          SEL_PRIO:      prioReg[regIdx] <= regData[PRIO_W-1:0];
          SEL_ENABLE:    enReg <= regData[NUM_IRQ-1:0];
          SEL_ALLMASK:   allMask <= regData[0];
          SEL_THRESH:    thresh <= regData[PRIO_W-1:0];
          SEL_FAULTMASK: faultMask <= regData[0];
          SEL_BASE:      tableBase <= {regData[ADDR_W-1:2], 2'b00};
          default:       ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqn_ctl.sv
module irqn_ctl
  import irqn_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int DEP_W  = 4
) (
  input  logic              bestValid,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic [PRIO_W:0]   runPrio,
  input  logic              allMask,
  input  logic              faultMask,
  input  logic [PRIO_W-1:0] thresh,
  input  logic [DEP_W-1:0]  depth,
  input  logic              takeAck,
  input  logic              retStrobe,
  output logic              intReq,
  output ctlStrobe_t        strobe
);
  logic [PRIO_W:0] ceiling;

  always_comb begin
    ceiling = runPrio;
    if (thresh != '0 && {1'b0, thresh} < ceiling) ceiling = {1'b0, thresh};
  end

  assign intReq      = bestValid && !allMask && !faultMask && ({1'b0, bestPrio} < ceiling);
  assign strobe.take = intReq && takeAck;
  assign strobe.pop  = retStrobe && (depth != '0);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irqn_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int DEP_W  = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqLine,
  input  logic               regWrEn,
  input  logic [2:0]         regSel,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [ADDR_W-1:0]  regData,
  input  logic               takeAck,
  input  logic               retStrobe,
  output logic               intReq,
  output logic [7:0]         excNum,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [PRIO_W:0]    runPrio
);
  ctlStrobe_t        strobe;
  logic              bestValid, allMask, faultMask;
  logic [PRIO_W-1:0] bestPrio, thresh;
  logic [DEP_W-1:0]  depth;

  irqn_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .EXC_OFS(16), .EXC_W(8)) uDp (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .regWrEn(regWrEn), .regSel(regSel),
    .regIdx(regIdx), .regData(regData), .strobe(strobe), .bestValid(bestValid),
    .bestPrio(bestPrio), .runPrio(runPrio), .allMask(allMask), .faultMask(faultMask),
    .thresh(thresh), .depth(depth), .excNum(excNum), .vecAddr(vecAddr)
  );

  irqn_ctl #(.PRIO_W(PRIO_W), .DEP_W(DEP_W)) uCtl (
    .bestValid(bestValid), .bestPrio(bestPrio), .runPrio(runPrio), .allMask(allMask),
    .faultMask(faultMask), .thresh(thresh), .depth(depth), .takeAck(takeAck),
    .retStrobe(retStrobe), .intReq(intReq), .strobe(strobe)
  );
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk #(
  parameter int PRIO_W = 3,
  parameter int DEP_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              intReq,
  input logic              takeAck,
  input logic              retStrobe,
  input logic              regWrEn,
  input logic [PRIO_W:0]   runPrio,
  input logic [PRIO_W-1:0] bestPrio,
  input logic              allMask,
  input logic              faultMask,
  input logic [DEP_W-1:0]  depth,
  input logic [ADDR_W-1:0] vecAddr
);
  localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1 << PRIO_W);

  // R10 R11
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (!allMask && !faultMask));

  // R4
  preempt_strict_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ({1'b0, bestPrio} < runPrio));

  // R6
  take_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && takeAck && !regWrEn && !retStrobe) |=> (runPrio == {1'b0, $past(bestPrio)}));

  // R7
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !(intReq && takeAck) && depth != '0) |=> (depth == $past(depth) - DEP_W'(1)));

  // R7
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (depth == '0) |-> (runPrio == IDLE));

  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (vecAddr[1:0] == 2'b00));
endmodule

bind irq_nest_ctrl irqn_chk #(.PRIO_W(PRIO_W), .DEP_W(DEP_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .intReq(intReq), .takeAck(takeAck), .retStrobe(retStrobe),
  .regWrEn(regWrEn), .runPrio(runPrio), .bestPrio(bestPrio), .allMask(allMask),
  .faultMask(faultMask), .depth(depth), .vecAddr(vecAddr)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  irqLine = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [2:0]  regIdx = '0;
  logic [31:0] regData = '0;
  logic        takeAck = 1'b0;
  logic        retStrobe = 1'b0;
  logic        intReq;
  logic [7:0]  excNum;
  logic [31:0] vecAddr;
  logic [3:0]  runPrio;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .regWrEn(regWrEn), .regSel(regSel),
    .regIdx(regIdx), .regData(regData), .takeAck(takeAck), .retStrobe(retStrobe),
    .intReq(intReq), .excNum(excNum), .vecAddr(vecAddr), .runPrio(runPrio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; irqLine = '0; regWrEn = 1'b0; takeAck = 1'b0; retStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [2:0] idx, input logic [31:0] data);
    regWrEn = 1'b1; regSel = sel; regIdx = idx; regData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] mask);
    irqLine = mask;
    @(negedge clk);
    irqLine = '0;
  endtask

  task automatic take();
    takeAck = 1'b1;
    @(negedge clk);
    takeAck = 1'b0;
  endtask

  task automatic ret();
    retStrobe = 1'b1;
    @(negedge clk);
    retStrobe = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 no request", 32'(intReq), 0);
    chk("R1 idle prio", 32'(runPrio), 8);
    pulse(8'h01);
    chk("R1 lines disabled", 32'(intReq), 0);
    wrReg(3'd1, 0, 32'hFF);
    chk("R1 base zero vector", vecAddr, 64);
  endtask

  task automatic tBasic();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd0, 3, 5);
    pulse(8'h08);
    chk("R2 edge pends", 32'(intReq), 1);
    chk("R5 excNum", 32'(excNum), 19);
    chk("R5 vecAddr", vecAddr, 76);
    take();
    chk("R6 pending cleared", 32'(intReq), 0);
    chk("R6 running prio", 32'(runPrio), 5);
    ret();
    chk("R7 idle after return", 32'(runPrio), 8);
    chk("R6 not re-offered", 32'(intReq), 0);
  endtask

  task automatic tArb();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd0, 2, 4);
    wrReg(3'd0, 5, 4);
    wrReg(3'd0, 6, 2);
    pulse(8'h64);
    chk("R3 lowest value wins", 32'(excNum), 22);
    wrReg(3'd0, 6, 6);
    chk("R9 R3 tie lower index", 32'(excNum), 18);
  endtask

  task automatic tNest();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd0, 2, 4);
    wrReg(3'd0, 5, 4);
    wrReg(3'd0, 1, 3);
    pulse(8'h04);
    take();
    chk("R6 nest first", 32'(runPrio), 4);
    pulse(8'h20);
    chk("R4 equal no preempt", 32'(intReq), 0);
    pulse(8'h02);
    chk("R4 better preempts", 32'(intReq), 1);
    chk("R4 better excNum", 32'(excNum), 17);
    take();
    chk("R6 nested prio", 32'(runPrio), 3);
    ret();
    chk("R7 restored prio", 32'(runPrio), 4);
    chk("R4 equal still held", 32'(intReq), 0);
    ret();
    chk("R7 idle", 32'(runPrio), 8);
    chk("R7 held one offered", 32'(excNum), 21);
  endtask

  task automatic tReentry();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd0, 4, 5);
    pulse(8'h10);
    take();
    wrReg(3'd0, 4, 0);
    pulse(8'h10);
    chk("R8 active blocked", 32'(intReq), 0);
    ret();
    chk("R8 offered after return", 32'(intReq), 1);
    chk("R8 excNum", 32'(excNum), 20);
  endtask

  task automatic tMasks();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    pulse(8'h80);
    chk("R2 pending", 32'(intReq), 1);
    wrReg(3'd2, 0, 1);
    chk("R10 all mask blocks", 32'(intReq), 0);
    wrReg(3'd2, 0, 0);
    chk("R10 mask cleared", 32'(intReq), 1);
    wrReg(3'd4, 0, 1);
    chk("R11 fault mask blocks", 32'(intReq), 0);
    wrReg(3'd4, 0, 0);
    chk("R11 mask cleared", 32'(intReq), 1);
  endtask

  task automatic tThresh();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd0, 3, 3);
    wrReg(3'd3, 0, 3);
    pulse(8'h08);
    chk("R12 at threshold blocked", 32'(intReq), 0);
    wrReg(3'd0, 3, 2);
    chk("R12 above threshold passes", 32'(intReq), 1);
    wrReg(3'd0, 3, 7);
    chk("R12 low prio blocked", 32'(intReq), 0);
    wrReg(3'd3, 0, 0);
    chk("R12 zero disables", 32'(intReq), 1);
  endtask

  task automatic tBase();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    wrReg(3'd5, 0, 32'h2000_0103);
    pulse(8'h01);
    chk("R13 R5 relocated vector", vecAddr, 32'h2000_0140);
  endtask

  task automatic tEnable();
    doReset();
    pulse(8'h40);
    chk("R2 disabled held", 32'(intReq), 0);
    wrReg(3'd1, 0, 32'h40);
    chk("R2 enabled offers", 32'(intReq), 1);
    chk("R2 enabled excNum", 32'(excNum), 22);
  endtask

  task automatic tLevel();
    doReset();
    wrReg(3'd1, 0, 32'hFF);
    irqLine = 8'h02;
    @(negedge clk);
    chk("R2 rise pends", 32'(intReq), 1);
    take();
    ret();
    chk("R2 held level no repend", 32'(intReq), 0);
    irqLine = '0;
  endtask

  task automatic tEmptyRet();
    doReset();
    ret();
    chk("R7 empty return ignored", 32'(runPrio), 8);
    wrReg(3'd1, 0, 32'hFF);
    pulse(8'h04);
    take();
    chk("R7 depth intact", 32'(runPrio), 0);
    ret();
    chk("R7 back to idle", 32'(runPrio), 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tReset();
    tBasic();
    tArb();
    tNest();
    tReentry();
    tMasks();
    tThresh();
    tBase();
    tEnable();
    tLevel();
    tEmptyRet();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule